// File: doc/BRIEF.md
# SDRAM Refresh and Power-Mode Sequencer

This block lives inside a memory bus controller. It decides when the attached SDRAM gets precharge-all, auto-refresh and self-refresh commands, and it decides how the clock-enable pin is driven. Four configuration bits steer it: refresh on or off, auto-refresh or self-refresh, power-down allowed, and a slow-clock timing option. A programmable interval sets how often auto-refresh happens.

The main access engine talks to it through three signals. It raises a request and waits for a grant before it starts an SDRAM access. It holds a busy flag while that access runs. It pulses a done strobe when an access to some other memory type completes, and that strobe is what can put the SDRAM into power-down. Whenever a maintenance sequence is running, the block withholds the grant.

In slow-clock mode the command pins and the clock-enable pin move half a cycle later, on the falling clock edge. Read data is then captured on the falling edge too. This gives extra hold time when the SDRAM clock is slow.

Top module: `sdram_pwr_seq`

## Requirements
- R1: With `cfg_ref_en` low, no precharge-all and no refresh command is ever driven, however long the block runs.
- R2: With `cfg_ref_en` high and `cfg_self_mode` low, the interval counter counts from 0 up to `cfg_interval`, so a refresh falls due every `cfg_interval`+1 cycles. Consecutive auto-refresh commands are then spaced exactly that far apart when the SDRAM is idle. Each auto-refresh comes TRP+1 cycles after its precharge-all. On the pins {cs_n,ras_n,cas_n,we_n}: NOP is 0111, precharge-all is 0010, refresh is 0001.
- R3: A refresh that falls due while `sd_busy` is high waits, with no precharge-all driven. It starts with precharge-all in the first cycle after `sd_busy` falls.
- R4: `acc_gnt` stays low from the precharge-all cycle until TRFC cycles after the auto-refresh cycle.
- R5: Raising `cfg_self_mode` with `cfg_ref_en` high starts self-refresh at once, with no wait for the interval counter. The sequence is precharge-all in the next cycle, then TRP NOP cycles, then refresh with CKE low in the same cycle. After that, CKE stays low, only NOP is driven and no grant is given.
- R6: Clearing `cfg_self_mode` or `cfg_ref_en` during self-refresh raises CKE in the next cycle. The grant is then withheld for TXSR cycles and allowed in the cycle after.
- R7: With `cfg_pdown_en` high, an `other_done` pulse drives CKE low in the next cycle. A later `acc_req` raises CKE in the next cycle, and `acc_gnt` comes one cycle after that.
- R8: With `cfg_pdown_en` low, an `other_done` pulse leaves CKE high.
- R9: When a self-refresh request and a power-down trigger arrive in the same cycle, self-refresh wins: precharge-all is driven with CKE high.
- R10: With `cfg_slow` low, the command pins and CKE change on the rising clock edge. With it high, they change on the falling edge, half a cycle later.
- R11: `rd_cap` holds `rd_in` as captured on the rising edge when `cfg_slow` is low, and as captured on the falling edge when it is high.
- R12: While reset is high and right after it falls, the pins show NOP with CKE high and `rd_cap` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ref_en | input | 1 | Refresh enable |
| cfg_self_mode | input | 1 | 1 selects self-refresh, 0 selects timed auto-refresh |
| cfg_pdown_en | input | 1 | Allow power-down after an access to another memory |
| cfg_slow | input | 1 | Shift commands and read capture to the falling edge |
| cfg_interval | input | IW | Refresh interval compare value |
| sd_busy | input | 1 | An SDRAM access is in progress |
| other_done | input | 1 | One-cycle pulse: an access to another memory type finished |
| acc_req | input | 1 | Access engine requests an SDRAM access |
| rd_in | input | DW | Read data from the SDRAM |
| acc_gnt | output | 1 | SDRAM access allowed this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| rd_cap | output | DW | Captured read data |

## Verification
The assertions assume that the access engine raises `sd_busy` only for accesses it was granted. They also assume that `other_done` is a single-cycle pulse, and that configuration inputs and handshakes change only between clock edges. The bench keeps to this by changing every input late in the clock cycle, pulsing `other_done` for exactly one cycle, and holding `sd_busy` steady over whole windows.

The spacing checks use intervals longer than one full refresh sequence, so no refresh ever falls due during recovery. The only exception is the busy-window test, which holds a refresh back on purpose.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_PALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sd_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_TRP_W,
        ST_AREF,
        ST_TRFC_W,
        ST_SR_PRE,
        ST_SR_TRP_W,
        ST_SR_ENTER,
        ST_SELF,
        ST_SR_EXIT,
        ST_PD,
        ST_PD_EXIT
    } seq_state_t;

    function automatic sd_cmd_t cmd_of(input seq_state_t s);
        case (s)
            ST_PRE, ST_SR_PRE:    cmd_of = CMD_PALL;
            ST_AREF, ST_SR_ENTER: cmd_of = CMD_REF;
            default:              cmd_of = CMD_NOP;
        endcase
    endfunction

    function automatic logic cke_of(input seq_state_t s);
        case (s)
            ST_SR_ENTER, ST_SELF, ST_PD: cke_of = 1'b0;
            default:                     cke_of = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
    parameter int IW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [IW-1:0] interval,
    input  logic          ack,
    output logic          pend
);
    logic [IW-1:0] cnt;
    logic          hit;

    assign hit = (cnt == interval);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            cnt <= hit ? '0 : cnt + 1'b1;
            if (hit)
                pend <= 1'b1;
            else if (ack)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/sdram_pwr_fsm.sv
module sdram_pwr_fsm
    import sdram_pwr_pkg::*;
#(
    parameter int TRP  = 2,
    parameter int TRFC = 4,
    parameter int TXSR = 6
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ref_en,
    input  logic    self_mode,
    input  logic    pdown_en,
    input  logic    pend,
    input  logic    sd_busy,
    input  logic    other_done,
    input  logic    acc_req,
    output logic    ref_ack,
    output logic    acc_gnt,
    output sd_cmd_t cmd_raw,
    output logic    cke_raw
);
    localparam int MAXW = (TRP > TRFC) ? ((TRP > TXSR) ? TRP : TXSR)
                                       : ((TRFC > TXSR) ? TRFC : TXSR);
    localparam int WW = $clog2(MAXW + 1);

    seq_state_t st, nxt;
    logic [WW-1:0] wcnt, wval;
    logic wload;
    logic want_sr, pend_ok, auto_go, go_pd;

    assign want_sr = ref_en && self_mode;
    assign pend_ok = pend && ref_en && !self_mode;
    assign auto_go = pend_ok && !sd_busy;
    assign go_pd   = other_done && pdown_en && !sd_busy && !want_sr && !pend_ok;

    always_comb begin
        nxt   = st;
        wload = 1'b0;
        wval  = '0;
        case (st)
            ST_IDLE: begin
                if (want_sr && !sd_busy) nxt = ST_SR_PRE;
                else if (auto_go)        nxt = ST_PRE;
                else if (go_pd)          nxt = ST_PD;
            end
            ST_PRE: begin
                nxt = ST_TRP_W; wload = 1'b1; wval = WW'(TRP - 1);
            end
            ST_TRP_W:    if (wcnt == '0) nxt = ST_AREF;
            ST_AREF: begin
                nxt = ST_TRFC_W; wload = 1'b1; wval = WW'(TRFC - 1);
            end
            ST_TRFC_W:   if (wcnt == '0) nxt = ST_IDLE;
            ST_SR_PRE: begin
                nxt = ST_SR_TRP_W; wload = 1'b1; wval = WW'(TRP - 1);
            end
            ST_SR_TRP_W: if (wcnt == '0) nxt = ST_SR_ENTER;
            ST_SR_ENTER: nxt = ST_SELF;
            ST_SELF: begin
                if (!want_sr) begin
                    nxt = ST_SR_EXIT; wload = 1'b1; wval = WW'(TXSR - 1);
                end
            end
            ST_SR_EXIT:  if (wcnt == '0) nxt = ST_IDLE;
            ST_PD:       if (acc_req || pend_ok || want_sr) nxt = ST_PD_EXIT;
            ST_PD_EXIT:  nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            wcnt <= '0;
        end else begin
            st <= nxt;
            if (wload)
                wcnt <= wval;
            else if (wcnt != '0)
                wcnt <= wcnt - 1'b1;
        end
    end

    assign ref_ack = (st == ST_AREF);
    assign acc_gnt = (st == ST_IDLE) && acc_req && !want_sr && !pend_ok && !go_pd;
    assign cmd_raw = cmd_of(st);
    assign cke_raw = cke_of(st);
endmodule

// File: rtl/sdram_cmd_edge.sv
module sdram_cmd_edge
    import sdram_pwr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slow,
    input  sd_cmd_t       cmd_raw,
    input  logic          cke_raw,
    input  logic [DW-1:0] rd_in,
    output sd_cmd_t       cmd_pin,
    output logic          cke_pin,
    output logic [DW-1:0] rd_cap
);
    sd_cmd_t       cmd_fall;
    logic          cke_fall;
    logic [DW-1:0] rd_rise, rd_fall;

    always_ff @(negedge clk) begin
        if (rst) begin
            cmd_fall <= CMD_NOP;
            cke_fall <= 1'b1;
            rd_fall  <= '0;
        end else begin
            cmd_fall <= cmd_raw;
            cke_fall <= cke_raw;
            rd_fall  <= rd_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_rise <= '0;
        else     rd_rise <= rd_in;
    end

    assign cmd_pin = slow ? cmd_fall : cmd_raw;
    assign cke_pin = slow ? cke_fall : cke_raw;
    assign rd_cap  = slow ? rd_fall  : rd_rise;
endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq
    import sdram_pwr_pkg::*;
#(
    parameter int IW   = 10,
    parameter int DW   = 16,
    parameter int TRP  = 2,
    parameter int TRFC = 4,
    parameter int TXSR = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_ref_en,
    input  logic          cfg_self_mode,
    input  logic          cfg_pdown_en,
    input  logic          cfg_slow,
    input  logic [IW-1:0] cfg_interval,
    input  logic          sd_busy,
    input  logic          other_done,
    input  logic          acc_req,
    input  logic [DW-1:0] rd_in,
    output logic          acc_gnt,
    output logic          sd_cs_n,
    output logic          sd_ras_n,
    output logic          sd_cas_n,
    output logic          sd_we_n,
    output logic          sd_cke,
    output logic [DW-1:0] rd_cap
);
    logic    pend, ref_ack, cke_raw;
    sd_cmd_t cmd_raw, cmd_pin;

    sdram_ref_timer #(.IW(IW)) u_tmr (
        .clk(clk), .rst(rst),
        .run(cfg_ref_en && !cfg_self_mode),
        .interval(cfg_interval), .ack(ref_ack), .pend(pend)
    );

    sdram_pwr_fsm #(.TRP(TRP), .TRFC(TRFC), .TXSR(TXSR)) u_fsm (
        .clk(clk), .rst(rst),
        .ref_en(cfg_ref_en), .self_mode(cfg_self_mode), .pdown_en(cfg_pdown_en),
        .pend(pend), .sd_busy(sd_busy), .other_done(other_done), .acc_req(acc_req),
        .ref_ack(ref_ack), .acc_gnt(acc_gnt), .cmd_raw(cmd_raw), .cke_raw(cke_raw)
    );

    sdram_cmd_edge #(.DW(DW)) u_out (
        .clk(clk), .rst(rst), .slow(cfg_slow),
        .cmd_raw(cmd_raw), .cke_raw(cke_raw), .rd_in(rd_in),
        .cmd_pin(cmd_pin), .cke_pin(sd_cke), .rd_cap(rd_cap)
    );

    assign sd_cs_n  = cmd_pin.cs_n;
    assign sd_ras_n = cmd_pin.ras_n;
    assign sd_cas_n = cmd_pin.cas_n;
    assign sd_we_n  = cmd_pin.we_n;
endmodule

// File: rtl/sdram_pwr_chk.sv
module sdram_pwr_chk
    import sdram_pwr_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    cfg_ref_en,
    input logic    sd_busy,
    input logic    acc_gnt,
    input sd_cmd_t cmd_raw,
    input logic    cke_raw
);
    // R1: a precharge-all only follows a cycle with refresh enabled
    a_r1_pall_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (cmd_raw == CMD_PALL) |-> $past(cfg_ref_en));

    // R3: maintenance never starts while an SDRAM access is running
    a_r3_pall_waits_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_raw == CMD_PALL) |-> !$past(sd_busy));

    // R4: a grant is only given when the bus is quiet and CKE is high
    a_r4_grant_only_quiet: assert property (@(posedge clk) disable iff (rst)
        acc_gnt |-> (cmd_raw == CMD_NOP && cke_raw));

    // R7: CKE was already high one cycle before any grant
    a_r7_cke_before_grant: assert property (@(posedge clk) disable iff (rst)
        acc_gnt |-> $past(cke_raw));

    // R5: self-refresh entry drops CKE in the refresh cycle itself
    a_r5_sr_cke_falls_with_ref: assert property (@(posedge clk) disable iff (rst)
        (cmd_raw == CMD_REF && !cke_raw) |-> $past(cke_raw));
endmodule

bind sdram_pwr_seq sdram_pwr_chk u_chk (
    .clk(clk), .rst(rst), .cfg_ref_en(cfg_ref_en), .sd_busy(sd_busy),
    .acc_gnt(acc_gnt), .cmd_raw(cmd_raw), .cke_raw(cke_raw)
);

// File: tb/tb_sdram_pwr_seq.sv
module tb_sdram_pwr_seq;
    localparam int IW = 10, DW = 16, TRP = 2, TRFC = 4, TXSR = 6;
    localparam logic [3:0] NOP = 4'b0111, PALL = 4'b0010, AREF = 4'b0001;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_ref_en = 0, cfg_self_mode = 0, cfg_pdown_en = 0, cfg_slow = 0;
    logic [IW-1:0] cfg_interval = '0;
    logic sd_busy = 0, other_done = 0, acc_req = 0;
    logic [DW-1:0] rd_in = '0;
    logic acc_gnt, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke;
    logic [DW-1:0] rd_cap;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    logic [3:0] e_cmd, l_cmd;
    logic e_cke, l_cke, l_gnt;

    sdram_pwr_seq #(.IW(IW), .DW(DW), .TRP(TRP), .TRFC(TRFC), .TXSR(TXSR)) dut (
        .clk(clk), .rst(rst), .cfg_ref_en(cfg_ref_en), .cfg_self_mode(cfg_self_mode),
        .cfg_pdown_en(cfg_pdown_en), .cfg_slow(cfg_slow), .cfg_interval(cfg_interval),
        .sd_busy(sd_busy), .other_done(other_done), .acc_req(acc_req), .rd_in(rd_in),
        .acc_gnt(acc_gnt), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_cke(sd_cke), .rd_cap(rd_cap)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
        e_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        e_cke = sd_cke;
        #12;
        l_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        l_cke = sd_cke;
        l_gnt = acc_gnt;
        cyc++;
    endtask

    task automatic rd_test(input logic slow, input logic [DW-1:0] a, input logic [DW-1:0] b);
        cfg_slow = slow;
        @(posedge clk);
        #1 rd_in = a;
        #11 rd_in = b;
        @(posedge clk);
        #5;
        chk(rd_cap == (slow ? a : b), slow ? "R11 falling capture" : "R11 rising capture",
            int'(rd_cap), int'(slow ? a : b));
        #12;
    endtask

    initial begin
        #4000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        int bad, nref, last_pre, last_ref, bgap, btrp, bhold, found;
        int ns[3];
        ns = '{8, 11, 17};

        // R12: reset state
        repeat (3) tick();
        chk(l_cmd == NOP && l_cke, "R12 during reset", int'(l_cmd), int'(NOP));
        rst = 0;
        tick();
        chk(l_cmd == NOP && l_cke && !l_gnt, "R12 after reset", int'({l_cmd, l_cke, l_gnt}), int'({NOP, 2'b10}));
        chk(rd_cap == '0, "R12 rd_cap", int'(rd_cap), 0);

        // R1: refresh disabled
        cfg_interval = 5; acc_req = 1; bad = 0;
        repeat (150) begin
            tick();
            if (l_cmd != NOP || !l_cke || !l_gnt) bad++;
        end
        chk(bad == 0, "R1 no maintenance when disabled", bad, 0);

        // R2 / R4: interval sweep
        for (int k = 0; k < 3; k++) begin
            cfg_interval = IW'(ns[k]); cfg_ref_en = 1;
            last_pre = -1000; last_ref = -1000; nref = 0; bgap = 0; btrp = 0; bhold = 0;
            repeat (6 * (ns[k] + 1) + 12) begin
                tick();
                if (l_cmd == PALL) last_pre = cyc;
                if (l_cmd == AREF) begin
                    if (cyc - last_pre != TRP + 1) btrp++;
                    if (nref > 0 && cyc - last_ref != ns[k] + 1) bgap++;
                    last_ref = cyc; nref++;
                end
                if (cyc - last_pre <= TRP + 1 + TRFC && l_gnt) bhold++;
            end
            chk(nref >= 5, "R2 refresh count", nref, 5);
            chk(bgap == 0, "R2 refresh spacing", bgap, 0);
            chk(btrp == 0, "R2 precharge to refresh gap", btrp, 0);
            chk(bhold == 0, "R4 grant held off", bhold, 0);
            cfg_ref_en = 0;
            repeat (TRP + TRFC + 4) tick();
        end

        // R3: refresh waits for busy
        acc_req = 0; sd_busy = 1; cfg_interval = 8; cfg_ref_en = 1; bad = 0;
        repeat (40) begin
            tick();
            if (l_cmd != NOP) bad++;
        end
        chk(bad == 0, "R3 no command while busy", bad, 0);
        sd_busy = 0;
        tick();
        chk(l_cmd == PALL, "R3 precharge after busy", int'(l_cmd), int'(PALL));
        cfg_ref_en = 0;
        repeat (TRP + TRFC + 4) tick();

        // R5 / R6: self-refresh entry and exit
        cfg_interval = 1000; acc_req = 1; cfg_ref_en = 1; cfg_self_mode = 1;
        tick();
        chk(l_cmd == PALL && l_cke, "R5 immediate precharge", int'(l_cmd), int'(PALL));
        bad = 0;
        repeat (TRP) begin tick(); if (l_cmd != NOP) bad++; end
        chk(bad == 0, "R5 precharge wait", bad, 0);
        tick();
        chk(l_cmd == AREF && !l_cke, "R5 refresh with CKE low", int'({l_cmd, l_cke}), int'({AREF, 1'b0}));
        bad = 0;
        repeat (40) begin tick(); if (l_cke || l_cmd != NOP || l_gnt) bad++; end
        chk(bad == 0, "R5 stays in self-refresh", bad, 0);
        cfg_self_mode = 0;
        tick();
        chk(l_cke && !l_gnt, "R6 CKE up at exit", int'({l_cke, l_gnt}), 2);
        bad = 0;
        repeat (TXSR - 1) begin tick(); if (l_gnt) bad++; end
        chk(bad == 0, "R6 exit delay", bad, 0);
        tick();
        chk(l_gnt == 1'b1, "R6 grant after exit", int'(l_gnt), 1);
        cfg_ref_en = 0; acc_req = 0;
        repeat (3) tick();

        // R7 / R8: power-down sweep
        for (int p = 0; p < 2; p++) begin
            cfg_pdown_en = logic'(p);
            other_done = 1;
            tick();
            other_done = 0;
            chk(l_cke == (p == 0), p ? "R7 CKE low after other access" : "R8 CKE stays high",
                int'(l_cke), (p == 0));
            bad = 0;
            repeat (30) begin tick(); if (l_cke != (p == 0)) bad++; end
            chk(bad == 0, p ? "R7 stays powered down" : "R8 stays active", bad, 0);
        end
        acc_req = 1;
        tick();
        chk(l_cke && !l_gnt, "R7 CKE up before grant", int'({l_cke, l_gnt}), 2);
        tick();
        chk(l_cke && l_gnt, "R7 grant after wake", int'({l_cke, l_gnt}), 3);
        acc_req = 0;
        tick();

        // R9: self-refresh wins over power-down
        cfg_ref_en = 1; cfg_self_mode = 1; other_done = 1;
        tick();
        other_done = 0;
        chk(l_cmd == PALL && l_cke, "R9 self-refresh priority", int'({l_cmd, l_cke}), int'({PALL, 1'b1}));
        repeat (TRP + 1) tick();
        chk(!l_cke, "R9 entered self-refresh", int'(l_cke), 0);
        cfg_ref_en = 0; cfg_self_mode = 0; cfg_pdown_en = 0;
        repeat (TXSR + 2) tick();

        // R10: edge selection for commands and CKE
        for (int s = 0; s < 2; s++) begin
            cfg_slow = logic'(s); cfg_interval = 8; cfg_ref_en = 1; found = 0;
            for (int i = 0; i < 30 && found == 0; i++) begin
                tick();
                if (l_cmd == PALL) found = 1;
            end
            chk(found == 1 && e_cmd == (s ? NOP : PALL), s ? "R10 command on falling edge" : "R10 command on rising edge",
                int'(e_cmd), int'(s ? NOP : PALL));
            cfg_ref_en = 0;
            repeat (TRP + TRFC + 4) tick();
            cfg_pdown_en = 1; other_done = 1;
            tick();
            other_done = 0;
            chk(e_cke == logic'(s) && !l_cke, s ? "R10 CKE on falling edge" : "R10 CKE on rising edge",
                int'({e_cke, l_cke}), s ? 2 : 0);
            acc_req = 1;
            repeat (3) tick();
            acc_req = 0; cfg_pdown_en = 0;
            tick();
        end

        // R11: read capture edge
        rd_test(1'b0, 16'h1234, 16'hABCD);
        rd_test(1'b1, 16'h5A5A, 16'hC3C3);
        rd_test(1'b0, 16'h00FF, 16'hFF00);

        summary();
    end
endmodule